// File: doc/BRIEF.md
# Switchable-Depth Serial Receive Buffer

This block is the receive-side byte store of a 16550-compatible serial port. Bytes arrive either from the line receiver (through a valid/ready pair) or, while the port is in loopback, from writes to the transmit data register. The host takes bytes out by reading the data register. A byte written into the FIFO control register selects the storage depth: one entry (plain holding-register behaviour) or the full FIFO depth. The same write can also ask for a receive flush.

The store is a circular buffer with independent read and write indices. A stored-byte count decides full and empty, and the index wrap point follows the depth in force. The line-status logic reads three things from this block: the occupancy count, a non-empty flag and a sticky overrun flag. It clears the overrun flag with a one-cycle strobe after it has reported it.

Top module: `sio_rx_fifo`

## Requirements
- R1: After reset the occupancy is 0, the stored control value is 0x00, the depth is 1, the overrun flag is 0 and `rd_data` shows 0xFF.
- R2: The depth is DEPTH (16) while stored control bit 0 (enable) is 1, and 1 while it is 0. The buffer is full when the occupancy equals the depth. Outside loopback, `rx_ready` is low exactly when the buffer is full.
- R3: A control write whose bit 0 differs from the stored bit 0 empties the buffer, in either direction.
- R4: A control write with bit 0 clear stores 0x00, whatever its other bits are.
- R5: A control write with bit 0 set stores the written value ANDed with 0xC9, keeping bit 0 (enable), bit 3 (DMA mode) and bits 7:6 (trigger). If bit 1 (receive reset) is also set, the buffer is emptied.
- R6: A push into a full buffer is refused and changes neither the contents nor the occupancy. A refused loopback push sets `overrun`. A refused line push does not. `ovr_clr` clears `overrun`, and a new overrun in the same cycle takes priority over the clear.
- R7: Bytes leave in the order they arrived, including across the wrap of the indices.
- R8: While the buffer is empty, `rd_data` is 0xFF, and a read changes neither the occupancy nor the order of later bytes.
- R9: A push and a pop in the same cycle on a buffer that is neither empty nor full leave the occupancy unchanged and advance the head to the next byte.
- R10: While `lb_en` is 1, pushes come only from `lb_wr`/`lb_data`, line bytes are discarded and `rx_ready` is 1. While `lb_en` is 0, `lb_wr` has no effect.
- R11: A push or pop in the same cycle as a control write that empties the buffer is discarded, and the occupancy afterwards is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Line receiver offers a byte |
| rx_data | input | DATA_W | Byte from the line receiver |
| rx_ready | output | 1 | Byte from the line receiver is accepted or discarded this cycle |
| lb_en | input | 1 | Loopback mode selected |
| lb_wr | input | 1 | Host write to the transmit data register |
| lb_data | input | DATA_W | Byte written to the transmit data register |
| ctl_wr | input | 1 | Host write to the FIFO control register |
| ctl_data | input | 8 | Value written to the FIFO control register |
| rd_en | input | 1 | Host read of the data register (pops when non-empty) |
| rd_data | output | DATA_W | Head byte, or all ones when empty |
| ovr_clr | input | 1 | Line-status read clears the overrun flag |
| level | output | $clog2(DEPTH+1) | Number of stored bytes |
| not_empty | output | 1 | At least one byte stored |
| overrun | output | 1 | Sticky overrun flag |
| ctl_q | output | 8 | Stored control value |

## Verification
The bench builds the block with its defaults, DATA_W = 8 and DEPTH = 16. At that depth the bench can reach a full buffer, a refused push and a wrap of both indices in a few dozen cycles, and it can switch back to the one-entry mode in the same run. In the one-entry mode the buffer fills after a single byte, so the overrun and refused-push paths can be hit at once. At the full depth the same paths need a long fill, which is what exercises the ordering across the wrap.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;
   localparam int          CTL_EN_BIT    = 0;
   localparam int          CTL_RXRST_BIT = 1;
   localparam logic [7:0]  CTL_KEEP_MASK = 8'hC9;

   function automatic logic [7:0] ctl_next(input logic [7:0] wr_val);
      return wr_val[CTL_EN_BIT] ? (wr_val & CTL_KEEP_MASK) : 8'h00;
   endfunction
endpackage

// File: rtl/sio_rx_ctl.sv
module sio_rx_ctl
   import sio_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [7:0] wr_val,
   output logic [7:0] ctl_q,
   output logic       wide,
   output logic       flush
);
   logic mode_flip;
   logic rx_rst_req;

   assign mode_flip  = wr_val[CTL_EN_BIT] ^ ctl_q[CTL_EN_BIT];
   assign rx_rst_req = wr_val[CTL_EN_BIT] & wr_val[CTL_RXRST_BIT];
   assign flush      = wr & (mode_flip | rx_rst_req);
   assign wide       = ctl_q[CTL_EN_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n)  ctl_q <= 8'h00;
      else if (wr) ctl_q <= ctl_next(wr_val);
   end
endmodule

// File: rtl/sio_rx_ring.sv
module sio_rx_ring #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wide,
   input  logic              flush,
   input  logic              push_req,
   input  logic              pop_req,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] head,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty
);
   localparam logic [CNT_W-1:0] LIM_WIDE = CNT_W'(DEPTH);
   localparam logic [PTR_W-1:0] LAST_IX  = PTR_W'(DEPTH - 1);

   generate
      if (DEPTH < 2)  begin : g_bad_depth $error("DEPTH must be at least 2"); end
      if (DATA_W < 1) begin : g_bad_width $error("DATA_W must be positive");  end
   endgenerate

   logic [PTR_W-1:0]             wr_ix, rd_ix;
   logic [CNT_W-1:0]             lim;
   logic                         do_push, do_pop;
   logic [DEPTH-1:0][DATA_W-1:0] cells;

   assign lim     = wide ? LIM_WIDE : CNT_W'(1);
   assign full    = (count == lim);
   assign empty   = (count == '0);
   assign do_push = push_req & ~full  & ~flush;
   assign do_pop  = pop_req  & ~empty & ~flush;
   assign head    = cells[rd_ix];

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] ix, input logic w);
      if (!w || ix == LAST_IX) return '0;
      return ix + PTR_W'(1);
   endfunction

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_cell
         logic [DATA_W-1:0] cell_q;
         always_ff @(posedge clk) begin
            if (do_push && wr_ix == PTR_W'(g)) cell_q <= wdata;
         end
         assign cells[g] = cell_q;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ix <= '0;
         rd_ix <= '0;
         count <= '0;
      end else begin
         if (do_push) wr_ix <= bump(wr_ix, wide);
         if (do_pop)  rd_ix <= bump(rd_ix, wide);
         case ({do_push, do_pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   input  logic              lb_en,
   input  logic              lb_wr,
   input  logic [DATA_W-1:0] lb_data,
   input  logic              ctl_wr,
   input  logic [7:0]        ctl_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic              ovr_clr,
   output logic [CNT_W-1:0]  level,
   output logic              not_empty,
   output logic              overrun,
   output logic [7:0]        ctl_q
);
   logic              wide, flush, full, empty;
   logic              push_req;
   logic [DATA_W-1:0] push_val, head;

   sio_rx_ctl u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (ctl_wr),
      .wr_val (ctl_data),
      .ctl_q  (ctl_q),
      .wide   (wide),
      .flush  (flush)
   );

   assign push_req = lb_en ? lb_wr   : rx_valid;
   assign push_val = lb_en ? lb_data : rx_data;

   sio_rx_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .wide     (wide),
      .flush    (flush),
      .push_req (push_req),
      .pop_req  (rd_en),
      .wdata    (push_val),
      .head     (head),
      .count    (level),
      .full     (full),
      .empty    (empty)
   );

   assign rx_ready  = lb_en | ~full;
   assign not_empty = ~empty;
   assign rd_data   = empty ? {DATA_W{1'b1}} : head;

   always_ff @(posedge clk) begin
      if (!rst_n)                               overrun <= 1'b0;
      else if (lb_en && lb_wr && full && !flush) overrun <= 1'b1;
      else if (ovr_clr)                         overrun <= 1'b0;
   end
endmodule

// File: rtl/sio_rx_chk.sv
module sio_rx_chk #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              lb_en,
   input logic              lb_wr,
   input logic              ctl_wr,
   input logic [7:0]        ctl_data,
   input logic              rd_en,
   input logic [DATA_W-1:0] rd_data,
   input logic [CNT_W-1:0]  level,
   input logic              overrun,
   input logic [7:0]        ctl_q
);
   logic [CNT_W-1:0] depth_now;
   assign depth_now = ctl_q[0] ? CNT_W'(DEPTH) : CNT_W'(1);

   p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      level <= depth_now);
   p_ready_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lb_en |-> (rx_ready == (level != depth_now)));
   p_flip_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_data[0] != ctl_q[0]) |=> level == '0);
   p_ctl_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !ctl_data[0]) |=> ctl_q == 8'h00);
   p_ctl_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_data[0]) |=> ctl_q == ($past(ctl_data) & 8'hC9));
   p_ovr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lb_en && lb_wr && level == depth_now && !ctl_wr) |=> overrun);
   p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0) |-> rd_data == {DATA_W{1'b1}});
   p_both_ops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!lb_en && rx_valid && rd_en && level != '0 && level != depth_now && !ctl_wr)
      |=> $stable(level));
endmodule

bind sio_rx_fifo sio_rx_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
   .lb_en(lb_en), .lb_wr(lb_wr), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
   .rd_en(rd_en), .rd_data(rd_data), .level(level), .overrun(overrun),
   .ctl_q(ctl_q)
);

// File: tb/sim_sio_rx_fifo.sv
module sim_sio_rx_fifo;
   localparam int DW = 8;
   localparam int DP = 16;
   localparam int LW = $clog2(DP + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic rx_valid = 0, lb_en = 0, lb_wr = 0, ctl_wr = 0, rd_en = 0, ovr_clr = 0;
   logic [DW-1:0] rx_data = '0, lb_data = '0;
   logic [7:0] ctl_data = '0;
   logic rx_ready, not_empty, overrun;
   logic [DW-1:0] rd_data;
   logic [LW-1:0] level;
   logic [7:0] ctl_q;
   int n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   sio_rx_fifo #(.DATA_W(DW), .DEPTH(DP)) u0 (
      .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_ready(rx_ready), .lb_en(lb_en), .lb_wr(lb_wr), .lb_data(lb_data),
      .ctl_wr(ctl_wr), .ctl_data(ctl_data), .rd_en(rd_en), .rd_data(rd_data),
      .ovr_clr(ovr_clr), .level(level), .not_empty(not_empty),
      .overrun(overrun), .ctl_q(ctl_q)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // One cycle: drive at negedge, pre-edge rd_data sampled, released after edge.
   task automatic cyc(input logic rv, input logic [7:0] rd_d, input logic lw,
                      input logic [7:0] ld, input logic cw, input logic [7:0] cd,
                      input logic re, input logic oc, output logic [7:0] pre);
      @(negedge clk);
      rx_valid = rv; rx_data = rd_d; lb_wr = lw; lb_data = ld;
      ctl_wr = cw; ctl_data = cd; rd_en = re; ovr_clr = oc;
      #1 pre = rd_data;
      @(posedge clk);
      #2;
      rx_valid = 0; lb_wr = 0; ctl_wr = 0; rd_en = 0; ovr_clr = 0;
   endtask

   task automatic push(input logic [7:0] d);
      logic [7:0] p; cyc(1, d, 0, 0, 0, 0, 0, 0, p);
   endtask
   task automatic pop(output logic [7:0] v);
      cyc(0, 0, 0, 0, 0, 0, 1, 0, v);
   endtask
   task automatic ctl(input logic [7:0] c);
      logic [7:0] p; cyc(0, 0, 0, 0, 1, c, 0, 0, p);
   endtask

   // {op[2], data[8], level[5], head[8], ctl_q[8], read_value[8]}
   // op: 0 line push, 1 read, 2 control write
   localparam logic [38:0] TBL [14] = '{
      {2'd0, 8'h11, 5'd1, 8'h11, 8'h00, 8'h00},
      {2'd0, 8'h22, 5'd1, 8'h11, 8'h00, 8'h00},
      {2'd1, 8'h00, 5'd0, 8'hFF, 8'h00, 8'h11},
      {2'd2, 8'hC7, 5'd0, 8'hFF, 8'hC1, 8'h00},
      {2'd0, 8'h31, 5'd1, 8'h31, 8'hC1, 8'h00},
      {2'd0, 8'h32, 5'd2, 8'h31, 8'hC1, 8'h00},
      {2'd0, 8'h33, 5'd3, 8'h31, 8'hC1, 8'h00},
      {2'd1, 8'h00, 5'd2, 8'h32, 8'hC1, 8'h31},
      {2'd2, 8'hC9, 5'd2, 8'h32, 8'hC9, 8'h00},
      {2'd2, 8'h0B, 5'd0, 8'hFF, 8'h09, 8'h00},
      {2'd0, 8'h44, 5'd1, 8'h44, 8'h09, 8'h00},
      {2'd2, 8'hFE, 5'd0, 8'hFF, 8'h00, 8'h00},
      {2'd0, 8'h55, 5'd1, 8'h55, 8'h00, 8'h00},
      {2'd1, 8'h00, 5'd0, 8'hFF, 8'h00, 8'h55}
   };

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 level", int'(level), 0);
      check("R1 ctl_q", int'(ctl_q), 0);
      check("R1 overrun", int'(overrun), 0);
      check("R1 rd_data", int'(rd_data), 'hFF);
      check("R1 ready", int'(rx_ready), 1);

      // Table walk: R2, R4, R5, R3, R7, R6
      for (int i = 0; i < 14; i++) begin
         logic [1:0] op; logic [7:0] d, h, cq, rv; logic [4:0] lv;
         {op, d, lv, h, cq, rv} = TBL[i];
         case (op)
            2'd0: push(d);
            2'd1: begin pop(v); check("R7 table read", int'(v), int'(rv)); end
            default: ctl(d);
         endcase
         check("R2/R4/R5 table level", int'(level), int'(lv));
         check("R7 table head", int'(rd_data), int'(h));
         check("R4/R5 table ctl_q", int'(ctl_q), int'(cq));
      end

      // R2/R6/R7: fill deep buffer, refuse 17th, wrap indices
      ctl(8'h01);
      for (int i = 0; i < DP; i++) push(8'(8'h80 + i));
      check("R2 full level", int'(level), DP);
      check("R2 ready low when full", int'(rx_ready), 0);
      push(8'hEE);
      check("R6 refused line push level", int'(level), DP);
      check("R6 line push no overrun", int'(overrun), 0);
      for (int i = 0; i < 10; i++) begin
         pop(v); check("R7 order first pass", int'(v), 'h80 + i);
      end
      for (int i = 0; i < 8; i++) push(8'(8'hA0 + i));
      check("R7 level after wrap", int'(level), 14);
      for (int i = 0; i < 14; i++) begin
         pop(v);
         check("R7 order across wrap", int'(v), (i < 6) ? ('h8A + i) : ('hA0 + i - 6));
      end

      // R8: empty read
      pop(v);
      check("R8 empty read value", int'(v), 'hFF);
      check("R8 empty read level", int'(level), 0);
      push(8'h5A);
      pop(v);
      check("R8 byte after empty read", int'(v), 'h5A);

      // R9: simultaneous push and pop
      push(8'h01); push(8'h02); push(8'h03);
      cyc(1, 8'h04, 0, 0, 0, 0, 1, 0, v);
      check("R9 popped value", int'(v), 'h01);
      check("R9 level unchanged", int'(level), 3);
      check("R9 head advanced", int'(rd_data), 'h02);

      // R3: flush when leaving FIFO mode with data present
      ctl(8'h00);
      check("R3 flush on disable", int'(level), 0);
      push(8'h66);
      ctl(8'h01);
      check("R3 flush on enable", int'(level), 0);
      check("R3 head after flush", int'(rd_data), 'hFF);

      // R11: push in same cycle as receive reset is discarded
      push(8'h70);
      cyc(1, 8'h71, 0, 0, 1, 8'h03, 1, 0, v);
      check("R11 level after flush cycle", int'(level), 0);

      // R10: loopback source selection
      ctl(8'h00);
      @(negedge clk) lb_en = 1;
      #1 check("R10 ready in loopback", int'(rx_ready), 1);
      push(8'h99);
      check("R10 line byte dropped", int'(level), 0);
      cyc(0, 0, 1, 8'h3C, 0, 0, 0, 0, v);
      check("R10 loopback byte stored", int'(rd_data), 'h3C);
      // R6: refused loopback push sets overrun, contents kept
      cyc(0, 0, 1, 8'h3D, 0, 0, 0, 0, v);
      check("R6 overrun set", int'(overrun), 1);
      check("R6 content kept", int'(rd_data), 'h3C);
      check("R6 level kept", int'(level), 1);
      cyc(0, 0, 1, 8'h3E, 0, 0, 0, 1, v);
      check("R6 set beats clear", int'(overrun), 1);
      cyc(0, 0, 0, 0, 0, 0, 1, 1, v);
      check("R6 overrun cleared", int'(overrun), 0);
      @(negedge clk) lb_en = 0;
      cyc(0, 0, 1, 8'h4F, 0, 0, 0, 0, v);
      check("R10 lb_wr ignored outside loopback", int'(level), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule